// File: doc/BRIEF.md
# SPI Status Poll Engine

This block is an SPI master that watches a configuration target until the target is ready for the next step. A controller asks for a poll with a one-cycle start pulse and an 8-bit condition mask. The engine then reads the target's one-byte status register again and again until one of three things happens: the status reports a protocol fault, the status shows the target is no longer busy and the mask condition holds, or the number of samples reaches a fixed limit. The engine then raises a one-cycle done pulse, a result code, and the status byte that ended the poll.

The first status byte the target sends after chip select falls may be stale. For this reason each status sample uses two identical chip-select framed transactions, each sending the status opcode, and the engine keeps only the byte from the second one. A simple mode-0 byte shifter is part of the block. SCK idles low, MISO is sampled on the rising edge, MOSI changes on the falling edge, and bits go most significant first. The SCK half period is a whole number of system clock cycles.

Top module: `spi_status_poller`

## Requirements
- R1: Every transaction sends the byte OPCODE (default 8'h00) MSB first with exactly 8 SCK pulses while cs_n_o is low. SCK is low whenever cs_n_o is high or the engine is idle.
- R2: Each status sample is two transactions, with cs_n_o going high between them. Only the byte from the second transaction is used for the decision and is reported on status_o.
- R3: Between any two transactions of one poll, cs_n_o stays high for at least two SCK periods (4*HALF_DIV system clock cycles).
- R4: If status bit 2 (violation) or bit 3 (fault) is set in a sample, the poll ends at that sample with result 2'b11 (error), whatever the other bits are.
- R5: While status bit 0 (busy) is set, polling continues, even if masked bits are set.
- R6: With busy clear and no error bits, the poll ends with result 2'b01 (success) if mask_i was zero at start, or if any bit set in the mask is set in the status. Otherwise polling continues.
- R7: If sample MAX_SAMPLES ends without success or error, the poll ends with result 2'b10 (timeout), after exactly MAX_SAMPLES samples.
- R8: start_i is accepted only while ready_o is high. A start during a poll has no effect on that poll's mask, samples or result.
- R9: done_o is high for exactly one cycle per poll. result_o and status_o update at done_o and then hold until the next done_o. ready_o is high again in the cycle done_o is high.
- R10: After reset: cs_n_o=1, sck_o=0, done_o=0, ready_o=1, result_o=2'b00, status_o=8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a poll (one-cycle pulse) |
| mask_i | input | 8 | Status condition mask, captured at start |
| ready_o | output | 1 | Engine idle and able to accept start |
| done_o | output | 1 | One-cycle pulse when a poll ends |
| result_o | output | 2 | 01 success, 10 timeout, 11 error |
| status_o | output | 8 | Status byte that ended the last poll |
| sck_o | output | 1 | SPI clock, mode 0 |
| mosi_o | output | 1 | SPI data to target |
| miso_i | input | 1 | SPI data from target |
| cs_n_o | output | 1 | SPI chip select, active low |

## Verification
A poll's results are due a variable number of cycles after start: two bytes of 16*HALF_DIV cycles each per sample, plus the gaps and one evaluation cycle. The bench therefore does not predict the cycle of done_o. It samples at each falling clock edge until done_o appears and then checks result_o, status_o and the number of sample pairs the target model served, all against a bench reference model. The line-level rules (opcode bits on SCK rising edges, eight pulses per frame, chip-select gap length) are measured continuously by the target model. One cycle after done_o, the bench checks that the pulse has dropped and that the results hold.

// File: rtl/sp_poll_pkg.sv
package sp_poll_pkg;

  localparam int BUSY_BIT = 0;
  localparam int VIOL_BIT = 2;
  localparam int FAULT_BIT = 3;

  typedef enum logic [1:0] {
    RES_NONE    = 2'b00,
    RES_OK      = 2'b01,
    RES_TIMEOUT = 2'b10,
    RES_ERROR   = 2'b11
  } poll_res_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_XFER,
    SQ_GAP,
    SQ_EVAL
  } seq_state_e;

  // Verdict for one status sample; RES_NONE means keep polling.
  function automatic poll_res_e judge(input logic [7:0] s, input logic [7:0] m,
                                      input logic last);
    if (s[VIOL_BIT] || s[FAULT_BIT])
      return RES_ERROR;
    if (!s[BUSY_BIT] && ((m == 8'h00) || ((s & m) != 8'h00)))
      return RES_OK;
    if (last)
      return RES_TIMEOUT;
    return RES_NONE;
  endfunction

endpackage

// File: rtl/sp_byte_shifter.sv
module sp_byte_shifter #(
  parameter int HALF_DIV = 2,
  parameter int NBITS    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [NBITS-1:0] tx_i,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             done_o,
  output logic [NBITS-1:0] rx_o
);
  localparam int PW = $clog2(HALF_DIV) + 1;
  localparam int BW = $clog2(NBITS) + 1;

  logic             active;
  logic [PW-1:0]    ph_cnt;
  logic [BW-1:0]    bit_cnt;
  logic [NBITS-1:0] tx_sr;
  logic [NBITS-1:0] rx_sr;
  logic             ph_end;

  assign ph_end = (ph_cnt == PW'(HALF_DIV - 1));
  assign mosi_o = tx_sr[NBITS-1];
  assign rx_o   = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      ph_cnt  <= '0;
      bit_cnt <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      sck_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i && !active) begin
        active  <= 1'b1;
        ph_cnt  <= '0;
        bit_cnt <= '0;
        tx_sr   <= tx_i;
        sck_o   <= 1'b0;
      end else if (active) begin
        if (ph_end) begin
          ph_cnt <= '0;
          if (!sck_o) begin
            sck_o <= 1'b1;
            rx_sr <= {rx_sr[NBITS-2:0], miso_i};
          end else begin
            sck_o <= 1'b0;
            if (bit_cnt == BW'(NBITS - 1)) begin
              active <= 1'b0;
              done_o <= 1'b1;
              tx_sr  <= '0;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              tx_sr   <= {tx_sr[NBITS-2:0], 1'b0};
            end
          end
        end else begin
          ph_cnt <= ph_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sp_poll_seq.sv
module sp_poll_seq
  import sp_poll_pkg::*;
#(
  parameter int HALF_DIV    = 2,
  parameter int MAX_SAMPLES = 10000,
  localparam int SW = $clog2(MAX_SAMPLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [7:0]    mask_i,
  input  logic          sh_done_i,
  input  logic [7:0]    sh_rx_i,
  output logic          sh_go_o,
  output logic          cs_n_o,
  output logic          ready_o,
  output logic          done_o,
  output logic [1:0]    result_o,
  output logic [7:0]    status_o,
  output logic [SW-1:0] sample_cnt_o
);
  localparam int GAP_CYC = 4 * HALF_DIV;
  localparam int GW = $clog2(GAP_CYC + 1);

  seq_state_e state;
  logic       second;
  logic [GW-1:0] gap_cnt;
  logic [7:0] mask_q;
  logic [7:0] status_q;
  logic       last_sample;
  poll_res_e  verdict;

  assign ready_o     = (state == SQ_IDLE);
  assign last_sample = (sample_cnt_o == SW'(MAX_SAMPLES - 1));
  assign verdict     = judge(status_q, mask_q, last_sample);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= SQ_IDLE;
      second       <= 1'b0;
      gap_cnt      <= '0;
      mask_q       <= '0;
      status_q     <= '0;
      sample_cnt_o <= '0;
      sh_go_o      <= 1'b0;
      cs_n_o       <= 1'b1;
      done_o       <= 1'b0;
      result_o     <= RES_NONE;
      status_o     <= '0;
    end else begin
      sh_go_o <= 1'b0;
      done_o  <= 1'b0;
      unique case (state)
        SQ_IDLE: if (start_i) begin
          mask_q       <= mask_i;
          sample_cnt_o <= '0;
          second       <= 1'b0;
          cs_n_o       <= 1'b0;
          sh_go_o      <= 1'b1;
          state        <= SQ_XFER;
        end
        SQ_XFER: if (sh_done_i) begin
          cs_n_o  <= 1'b1;
          gap_cnt <= '0;
          if (second) begin
            status_q <= sh_rx_i;
            state    <= SQ_EVAL;
          end else begin
            second <= 1'b1;
            state  <= SQ_GAP;
          end
        end
        SQ_GAP: begin
          if (gap_cnt == GW'(GAP_CYC - 1)) begin
            cs_n_o  <= 1'b0;
            sh_go_o <= 1'b1;
            state   <= SQ_XFER;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        SQ_EVAL: begin
          sample_cnt_o <= sample_cnt_o + 1'b1;
          if (verdict != RES_NONE) begin
            done_o   <= 1'b1;
            result_o <= verdict;
            status_o <= status_q;
            state    <= SQ_IDLE;
          end else begin
            second  <= 1'b0;
            gap_cnt <= '0;
            state   <= SQ_GAP;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_status_poller.sv
module spi_status_poller #(
  parameter int HALF_DIV    = 2,
  parameter int MAX_SAMPLES = 10000,
  parameter logic [7:0] OPCODE = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] mask_i,
  output logic       ready_o,
  output logic       done_o,
  output logic [1:0] result_o,
  output logic [7:0] status_o,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i,
  output logic       cs_n_o
);
  localparam int SW = $clog2(MAX_SAMPLES + 1);

  logic          sh_go;
  logic          sh_done;
  logic [7:0]    sh_rx;
  logic [SW-1:0] sample_cnt;

  sp_byte_shifter #(.HALF_DIV(HALF_DIV), .NBITS(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .go_i(sh_go), .tx_i(OPCODE), .miso_i(miso_i),
    .sck_o(sck_o), .mosi_o(mosi_o), .done_o(sh_done), .rx_o(sh_rx)
  );

  sp_poll_seq #(.HALF_DIV(HALF_DIV), .MAX_SAMPLES(MAX_SAMPLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
    .sh_done_i(sh_done), .sh_rx_i(sh_rx), .sh_go_o(sh_go), .cs_n_o(cs_n_o),
    .ready_o(ready_o), .done_o(done_o), .result_o(result_o),
    .status_o(status_o), .sample_cnt_o(sample_cnt)
  );
endmodule

// File: rtl/sp_poll_chk.sv
module sp_poll_chk #(
  parameter int HALF_DIV    = 2,
  parameter int MAX_SAMPLES = 10000,
  localparam int SW = $clog2(MAX_SAMPLES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready_o,
  input logic          done_o,
  input logic [1:0]    result_o,
  input logic [7:0]    status_o,
  input logic          sck_o,
  input logic          cs_n_o,
  input logic [SW-1:0] sample_cnt
);
  localparam int GAP_CYC = 4 * HALF_DIV;

  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (cs_n_o) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (cs_n_o && !sck_o));
  p_sck_framed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> !cs_n_o);
  p_cs_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n_o) && !$past(ready_o)) |-> (hi_cnt >= 16'(GAP_CYC)));
  p_err_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (status_o[2] || status_o[3])) |-> (result_o == 2'b11));
  p_ok_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o == 2'b01) |-> !status_o[0]);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_cnt <= SW'(MAX_SAMPLES));
  p_timeout_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o == 2'b10) |-> (sample_cnt == SW'(MAX_SAMPLES)));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ready_o);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(status_o)));
endmodule

bind spi_status_poller sp_poll_chk #(.HALF_DIV(HALF_DIV), .MAX_SAMPLES(MAX_SAMPLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready_o(ready_o), .done_o(done_o),
  .result_o(result_o), .status_o(status_o), .sck_o(sck_o), .cs_n_o(cs_n_o),
  .sample_cnt(sample_cnt)
);

// File: tb/sim_spi_status_poller.sv
`timescale 1ns/1ps
module sim_spi_status_poller;
  localparam int HALF = 2;
  localparam int MAXS = 20;
  localparam int GAPC = 4 * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] mask_i = 8'h00;
  logic ready_o, done_o, sck_o, mosi_o, cs_n_o;
  logic miso_i = 1'b0;
  logic [1:0] result_o;
  logic [7:0] status_o;

  always #4 clk = ~clk;

  spi_status_poller #(.HALF_DIV(HALF), .MAX_SAMPLES(MAXS), .OPCODE(8'h00)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
    .ready_o(ready_o), .done_o(done_o), .result_o(result_o), .status_o(status_o),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_n_o(cs_n_o)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // target model
  int unsigned busy_n;
  logic [7:0] busy_val, final_val;
  int tcount = 0;
  int rises = 0;
  int bad_rises = 0;
  int mosi_bad = 0;
  int min_gap = 1000;
  int hi_c = 0;
  logic prev_cs = 1'b1;
  logic [7:0] resp;

  function automatic logic [7:0] sample_val(input int k);
    return (k < int'(busy_n)) ? busy_val : final_val;
  endfunction

  always @(negedge cs_n_o) begin
    resp = (tcount % 2 == 0) ? 8'h0C : sample_val(tcount / 2);
    miso_i = resp[7];
    rises = 0;
  end
  always @(negedge sck_o) begin
    resp = {resp[6:0], 1'b0};
    miso_i = resp[7];
  end
  always @(posedge sck_o) begin
    rises++;
    if (mosi_o !== 1'b0) mosi_bad++;
  end
  always @(posedge cs_n_o) begin
    if (rst_n) begin
      if (rises != 8) bad_rises++;
      tcount++;
    end
  end
  always @(negedge clk) begin
    if (!cs_n_o && prev_cs && tcount > 0 && hi_c < min_gap) min_gap = hi_c;
    if (cs_n_o) hi_c++; else hi_c = 0;
    prev_cs = cs_n_o;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference verdict
  function automatic void expect_poll(input logic [7:0] m, output logic [1:0] res,
                                      output logic [7:0] st, output int n);
    res = 2'b10; st = sample_val(MAXS - 1); n = MAXS;
    for (int k = 0; k < MAXS; k++) begin
      logic [7:0] s;
      s = sample_val(k);
      if (s[2] || s[3]) begin res = 2'b11; st = s; n = k + 1; return; end
      if (!s[0] && (m == 8'h00 || (s & m) != 8'h00)) begin
        res = 2'b01; st = s; n = k + 1; return;
      end
    end
  endfunction

  task automatic run_poll(input int unsigned bn, input logic [7:0] bv,
                          input logic [7:0] fv, input logic [7:0] m,
                          input bit poke, input string req);
    logic [1:0] er; logic [7:0] es; int en; int cyc;
    busy_n = bn; busy_val = bv; final_val = fv;
    tcount = 0; mosi_bad = 0; bad_rises = 0; min_gap = 1000;
    expect_poll(m, er, es, en);
    @(negedge clk);
    mask_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; mask_i = 8'h00;
    cyc = 0;
    while (!done_o && cyc < 20000) begin
      if (poke && cyc == 40) begin start_i = 1'b1; mask_i = ~m; end
      else begin start_i = 1'b0; end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    check(done_o === 1'b1, req, "done seen", done_o, 1);
    check(result_o === er, req, "result", result_o, er);
    check(status_o === es, "R2", "status from second byte", status_o, es);
    check(tcount == 2 * en, "R2", "transactions", tcount, 2 * en);
    check(mosi_bad == 0 && bad_rises == 0, "R1", "opcode/pulses", mosi_bad + bad_rises, 0);
    if (en > 1 || tcount > 1)
      check(min_gap >= GAPC, "R3", "cs gap", min_gap, GAPC);
    check(ready_o === 1'b1, "R9", "ready at done", ready_o, 1);
    @(negedge clk);
    check(done_o === 1'b0, "R9", "done width", done_o, 0);
    check(result_o === er && status_o === es, "R9", "hold", {result_o, status_o}, {er, es});
    repeat (3) @(negedge clk);
    if (poke) check(tcount == 2 * en && cs_n_o === 1'b1, "R8", "ignored start", tcount, 2 * en);
  endtask

  task automatic finish_tb;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_tb();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R10 reset state
    check(cs_n_o === 1'b1 && sck_o === 1'b0, "R10", "lines", {cs_n_o, sck_o}, 2'b10);
    check(done_o === 1'b0 && ready_o === 1'b1, "R10", "handshake", {done_o, ready_o}, 2'b01);
    check(result_o === 2'b00 && status_o === 8'h00, "R10", "outputs", {result_o, status_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n_o === 1'b1 && sck_o === 1'b0, "R1", "idle lines", {cs_n_o, sck_o}, 2'b10);
    // directed
    run_poll(0, 8'h01, 8'h00, 8'h00, 0, "R6");
    run_poll(3, 8'h01, 8'h02, 8'h02, 0, "R6");
    run_poll(4, 8'h03, 8'h02, 8'h02, 0, "R5");
    run_poll(2, 8'h01, 8'h10, 8'h02, 0, "R7");
    run_poll(0, 8'h01, 8'h09, 8'h00, 0, "R4");
    run_poll(2, 8'h01, 8'h05, 8'h00, 0, "R4");
    run_poll(MAXS + 5, 8'h01, 8'h00, 8'h00, 0, "R7");
    run_poll(6, 8'h01, 8'h02, 8'h02, 1, "R8");
    // random
    for (int i = 0; i < 12; i++) begin
      int unsigned bn;
      logic [7:0] bv, fv, m;
      bn = $urandom % 6;
      bv = 8'h01 | (8'($urandom) & 8'hF2);
      fv = 8'($urandom);
      m  = ($urandom % 3 == 0) ? 8'h00 : (8'($urandom) & 8'hFE);
      run_poll(bn, bv, fv, m, (i % 4) == 1, "R6");
    end
    finish_tb();
  end
endmodule